// File: doc/BRIEF.md
# Four-Channel Buffered Pulse-Width Modulator

This block produces four independent pulse-width modulated outputs, each driven by its own 16-bit counter that advances on a power-of-two division of the system clock. Software sets up and controls the channels through a simple word-addressed register port. A write strobe stores data. A read strobe returns data one clock later.

Each channel keeps an active period and an active duty value. It also keeps a second pair of staging registers. A value written to a staging register waits until the channel's current period runs out. It is then copied into the active register, so a running waveform only changes at a period edge and never shows a partial cycle. Every period edge sets a per-channel flag in an event register, and reading that register clears the flag. A stop command is deferred in the same way: the channel stays in the running set until its period ends, and only then drops to its idle level.

Top module: `pwm4_buffered`

## Requirements
- R1: After reset, all channels are stopped, every output is low, and the running-status and event registers read 0.
- R2: Register map. Global registers:
  - 0x04: write-1-to-start, one bit per channel.
  - 0x08: write-1-to-stop.
  - 0x0C: running status, bit i for channel i.
  - 0x1C: period-end events.

  The channel i bank starts at 0x200 + 0x20*i:
  - +0x00: mode.
  - +0x04: active duty.
  - +0x08: staged duty.
  - +0x0C: active period.
  - +0x10: staged period.

  A read of any other offset returns 0.
- R3: Only bits [15:0] of a duty or period write are kept, and reads return them zero-extended. A write to an active duty or period register loads at once while the channel is stopped, and is ignored while it runs.
- R4: A running channel counts prescaled ticks from 0 up to period-1 and then wraps to 0. With mode bit 9 clear, the output is low while the count is below the active duty and high otherwise. It is therefore high for (period - duty) ticks of every period.
- R5: Mode bit 9 inverts the output. A stopped channel drives the level held in bit 9. The mode register reads back the polarity bit and the prescaler field [3:0] exactly as written.
- R6: Mode bits [3:0] = n make one counter tick every 2^n clocks. A value above 10 acts as 10.
- R7: A write to a staged duty or period register changes nothing in the running waveform. The active register keeps its old value until the end of the current period, and the staged value is copied over at that edge.
- R8: Every period end sets the channel's bit in the event register. A read of that register returns the pending bits and clears them.
- R9: After a stop write, the channel's running-status bit stays 1 and the output keeps toggling until the current period ends. After that edge the status bit is 0 and the output is at its idle level.
- R10: A start write to a stopped channel sets its running-status bit at once and restarts its counter at 0. Several channels can be started by a single write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; data appears on rdata after the next edge |
| addr | input | 12 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| pwm_out | output | 4 | Waveform outputs, bit i for channel i |

## Verification
The hardest situations to reach are those that depend on where an access falls relative to an invisible period edge. A staged write, the read-back of the old active value, and a stop command must all land early in a period, or the edge passes before the check. To get there, the stimulus first reads the event register to clear it, then polls it until the channel's bit comes back. That marks an edge only a few clocks in the past. The test access is issued right after, so a whole period lies ahead of it. Waveform shape is checked by counting high samples over a window of exactly one period, taken after the first period, so the result does not depend on the prescaler phase.

// File: rtl/pwm4_buffered.sv
module pwm4_buffered #(
  parameter int CNT_W   = 16,
  parameter int PRE_W   = 4,
  parameter int PRE_MAX = 10,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [3:0]        pwm_out
);
  localparam int NCH     = 4;
  localparam int POL_BIT = 9;
  localparam logic [ADDR_W-1:0] OFF_ENA = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] OFF_DIS = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] OFF_RUN = ADDR_W'('h0C);
  localparam logic [ADDR_W-1:0] OFF_EVT = ADDR_W'('h1C);
  localparam logic [ADDR_W-8:0] BANK_TAG = (ADDR_W-7)'(4);
  localparam logic [PRE_W-1:0]  PRE_LIM  = PRE_W'(PRE_MAX);
  localparam logic [PRE_MAX-1:0] ONES    = '1;

  logic [PRE_MAX-1:0] pre_cnt;
  logic [NCH-1:0]     evt_q;
  logic [NCH-1:0]     run_v, pol_v, bnd_v;
  logic [NCH-1:0][PRE_W-1:0] pre_v;
  logic [NCH-1:0][CNT_W-1:0] cnt_v, duty_v, dstg_v, per_v, pstg_v;
  logic [DATA_W-1:0]  rd_val;

  wire       bank_hit = addr[ADDR_W-1:7] == BANK_TAG;
  wire [1:0] ch_sel   = addr[6:5];
  wire [4:0] reg_off  = addr[4:0];
  wire       wr_ena   = wr_en && addr == OFF_ENA;
  wire       wr_dis   = wr_en && addr == OFF_DIS;
  wire       rd_evt   = rd_en && addr == OFF_EVT;

  always_ff @(posedge clk)
    if (!rst_n) pre_cnt <= '0;
    else        pre_cnt <= pre_cnt + 1'b1;

  for (genvar i = 0; i < NCH; i++) begin : gen_ch
    logic [CNT_W-1:0] cnt, duty, dstg, per, pstg;
    logic [PRE_W-1:0] pre;
    logic             pol, run, stop_req, dpend, ppend;

    wire              sel  = wr_en && bank_hit && ch_sel == 2'(i);
    wire [PRE_W-1:0]  psel = (pre > PRE_LIM) ? PRE_LIM : pre;
    wire [PRE_MAX-1:0] mask = ONES >> (PRE_LIM - psel);
    wire              tick = (pre_cnt & mask) == mask;
    wire [CNT_W:0]    nxt  = {1'b0, cnt} + 1'b1;
    wire              bnd  = run && tick && (nxt >= {1'b0, per});

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt <= '0; duty <= '0; dstg <= '0; per <= '0; pstg <= '0;
        pre <= '0; pol <= 1'b0; run <= 1'b0; stop_req <= 1'b0;
        dpend <= 1'b0; ppend <= 1'b0;
      end else begin
        if (bnd) begin
          cnt <= '0;
          if (dpend) duty <= dstg;
          if (ppend) per  <= pstg;
          dpend <= 1'b0;
          ppend <= 1'b0;
          if (stop_req) run <= 1'b0;
          stop_req <= 1'b0;
        end else if (run && tick) begin
          cnt <= cnt + 1'b1;
        end
        if (sel) begin
          case (reg_off)
            5'h00: begin pre <= wdata[PRE_W-1:0]; pol <= wdata[POL_BIT]; end
            5'h04: if (!run) duty <= wdata[CNT_W-1:0];
            5'h08: begin dstg <= wdata[CNT_W-1:0]; dpend <= 1'b1; end
            5'h0C: if (!run) per <= wdata[CNT_W-1:0];
            5'h10: begin pstg <= wdata[CNT_W-1:0]; ppend <= 1'b1; end
            default: ;
          endcase
        end
        if (wr_dis && wdata[i] && run) stop_req <= 1'b1;
        if (wr_ena && wdata[i]) begin
          stop_req <= 1'b0;
          if (!run || (bnd && stop_req)) begin
            run <= 1'b1;
            cnt <= '0;
          end
        end
      end
    end

    assign run_v[i]  = run;
    assign pol_v[i]  = pol;
    assign bnd_v[i]  = bnd;
    assign pre_v[i]  = pre;
    assign cnt_v[i]  = cnt;
    assign duty_v[i] = duty;
    assign dstg_v[i] = dstg;
    assign per_v[i]  = per;
    assign pstg_v[i] = pstg;
    assign pwm_out[i] = run ? ((cnt >= duty) ^ pol) : pol;
  end

  always_ff @(posedge clk)
    if (!rst_n)      evt_q <= '0;
    else if (rd_evt) evt_q <= bnd_v;
    else             evt_q <= evt_q | bnd_v;

  always_comb begin
    rd_val = '0;
    if (addr == OFF_RUN)      rd_val[NCH-1:0] = run_v;
    else if (addr == OFF_EVT) rd_val[NCH-1:0] = evt_q;
    else if (bank_hit) begin
      case (reg_off)
        5'h00: begin rd_val[PRE_W-1:0] = pre_v[ch_sel]; rd_val[POL_BIT] = pol_v[ch_sel]; end
        5'h04: rd_val[CNT_W-1:0] = duty_v[ch_sel];
        5'h08: rd_val[CNT_W-1:0] = dstg_v[ch_sel];
        5'h0C: rd_val[CNT_W-1:0] = per_v[ch_sel];
        5'h10: rd_val[CNT_W-1:0] = pstg_v[ch_sel];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk)
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_val;
endmodule

module pwm4_buffered_chk #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 rd_en,
  input logic [ADDR_W-1:0]    addr,
  input logic [DATA_W-1:0]    rdata,
  input logic [3:0]           pwm_out,
  input logic [3:0]           run_v,
  input logic [3:0]           pol_v,
  input logic [3:0]           bnd_v,
  input logic [3:0]           evt_q,
  input logic [3:0][CNT_W-1:0] cnt_v,
  input logic [3:0][CNT_W-1:0] duty_v,
  input logic [3:0][CNT_W-1:0] per_v
);
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_en) && $past(addr[ADDR_W-1:ADDR_W-2]) == 2'b10 |-> rdata == '0); // R2

  for (genvar i = 0; i < 4; i++) begin : gen_a
    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      !run_v[i] |-> pwm_out[i] == pol_v[i]); // R5
    AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      run_v[i] && per_v[i] != '0 |-> cnt_v[i] < per_v[i]); // R4
    AST_STOP_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(run_v[i]) |-> $past(bnd_v[i])); // R9
    AST_EVENT_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(bnd_v[i]) |-> evt_q[i]); // R8
    AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      run_v[i] && $past(run_v[i]) && !$past(bnd_v[i]) |-> $stable(duty_v[i]) && $stable(per_v[i])); // R7
  end
endmodule

bind pwm4_buffered pwm4_buffered_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .rdata(rdata),
  .pwm_out(pwm_out), .run_v(run_v), .pol_v(pol_v), .bnd_v(bnd_v), .evt_q(evt_q),
  .cnt_v(cnt_v), .duty_v(duty_v), .per_v(per_v)
);

// File: tb/test_pwm4_buffered.sv
module test_pwm4_buffered;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  pwm_out;

  int checks = 0, errors = 0;
  logic sb_rd = 1'b0, sb_seen = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  pwm4_buffered i_pwm4_buffered (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) sb_seen <= sb_rd;
  always @(negedge clk)
    if (sb_seen && exp_q.size() > 0) check(tag_q.pop_front(), rdata, exp_q.pop_front());

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_sb(logic [11:0] a, logic [31:0] e, string tag);
    @(negedge clk); rd_en = 1'b1; addr = a; sb_rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); rd_en = 1'b0; sb_rd = 1'b0;
  endtask

  task automatic rd_raw(logic [11:0] a, output logic [31:0] v);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); v = rdata; rd_en = 1'b0;
  endtask

  task automatic wait_edge(int ch);
    logic [31:0] v;
    rd_raw(12'h01C, v);
    for (int k = 0; k < 5000; k++) begin
      rd_raw(12'h01C, v);
      if (v[ch]) break;
    end
  endtask

  task automatic count_high(int ch, int n, int exp, string tag);
    int hi = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      hi += int'(pwm_out[ch]);
    end
    check(tag, hi, exp);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 outputs idle", pwm_out, 4'h0);
    rd_sb(12'h00C, 0, "R1 running status");
    rd_sb(12'h01C, 0, "R1 event status");

    wr(12'h20C, 32'h1234_000A);
    wr(12'h204, 32'hFFFF_0003);
    rd_sb(12'h20C, 32'h000A, "R3 period low bits");
    rd_sb(12'h204, 32'h0003, "R3 duty low bits");
    rd_sb(12'h100, 0, "R2 unmapped read");
    rd_sb(12'h214, 0, "R2 unused bank offset");

    wr(12'h004, 32'h1);
    rd_sb(12'h00C, 32'h1, "R10 start sets status");
    repeat (12) @(negedge clk);
    count_high(0, 10, 7, "R4 high ticks duty 3 of 10");

    wr(12'h204, 32'h5);
    rd_sb(12'h204, 32'h3, "R3 active write ignored while running");

    wait_edge(0);
    wr(12'h208, 32'h8);
    rd_sb(12'h204, 32'h3, "R7 active duty held before edge");
    rd_sb(12'h208, 32'h8, "R2 staged duty readback");
    wait_edge(0);
    rd_sb(12'h204, 32'h8, "R7 staged duty applied at edge");
    rd_sb(12'h01C, 0, "R8 event cleared by read");
    repeat (10) @(negedge clk);
    count_high(0, 10, 2, "R7 new waveform duty 8");

    wait_edge(0);
    wr(12'h008, 32'h1);
    rd_sb(12'h00C, 32'h1, "R9 status held after stop write");
    repeat (14) @(negedge clk);
    rd_sb(12'h00C, 0, "R9 status cleared after edge");
    check("R9 output idle after stop", pwm_out[0], 1'b0);

    wr(12'h220, 32'h202);
    rd_sb(12'h220, 32'h202, "R5 mode fields readback");
    check("R5 idle level follows polarity", pwm_out[1], 1'b1);
    wr(12'h22C, 32'h4);
    wr(12'h224, 32'h1);
    wr(12'h240, 32'h2);
    wr(12'h24C, 32'h5);
    wr(12'h244, 32'h1);
    wr(12'h004, 32'h6);
    rd_sb(12'h00C, 32'h6, "R10 two channels started together");
    repeat (40) @(negedge clk);
    count_high(1, 16, 4, "R5 inverted waveform");
    count_high(2, 20, 16, "R6 divide by 4");

    wr(12'h260, 32'hF);
    rd_sb(12'h260, 32'hF, "R6 prescaler field readback");
    wr(12'h26C, 32'h2);
    wr(12'h264, 32'h1);
    wr(12'h004, 32'h8);
    repeat (2100) @(negedge clk);
    count_high(3, 2048, 1024, "R6 field above 10 acts as 10");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) check("scoreboard drained", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule